// File: doc/BRIEF.md
# LCD Controller Power-Up Sequencer

This block brings an 84x48 monochrome LCD controller out of reset and into a known configuration. The link to the controller is a write-only serial port with a separate data/command select line. When the block sees a start pulse, it drives the panel's active-low reset line low for a minimum pulse width and then releases it. It waits a long settle time before it sends any byte.

After the settle time it sends six command bytes. Four of them use the extended instruction set and merge the configuration inputs into their opcodes: bias, temperature coefficient and operating voltage. The block then returns to the basic instruction set and selects normal or inverted display. A ready flag then reports that the panel can take pixel data.

All delays are counted in system clock cycles and derived from parameters. The serial clock divider comes from the system clock and the target serial rate. The byte shifter is a simple mode-0 shifter inside the block, sending most significant bit first. Chip select is framed around each byte.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: While reset is held and after it is released, before any start: `lcd_rst_n` is 1, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0 and `ready` is 0.
- R2: A `start` pulse sampled while `busy` is 0 makes `lcd_rst_n` 0 and `busy` 1 one cycle later, and clears `ready`.
- R3: `lcd_rst_n` stays low for at least RST_US microseconds of clock cycles and then returns high. The first falling edge of `spi_cs_n` comes at least SETTLE_US microseconds of cycles after that release.
- R4: Exactly six bytes are sent per sequence, in this order: 0x21, 0x10 OR bias[2:0], 0x04 OR tc[1:0], 0x80 OR vop[6:0], 0x20, then 0x0C OR inv (0x0C normal, 0x0D inverted).
- R5: Every byte of the sequence is a command: `lcd_dc` is 0 from the fall of `spi_cs_n` to its rise and does not change while `spi_cs_n` is low.
- R6: The serial port is mode 0, most significant bit first. `spi_sclk` is low when `spi_cs_n` falls. The receiver samples `spi_mosi` on each rising `spi_sclk` edge, with 8 rising edges per byte. `spi_mosi` is stable while `spi_sclk` is high. Each `spi_sclk` level, including the first low phase after `spi_cs_n` falls, lasts at least ceil(CLK_HZ / (2*SPI_HZ)) cycles.
- R7: Configuration inputs are captured on the accepted start. Changes to them later in the sequence have no effect on the bytes sent.
- R8: A `start` pulse while `busy` is 1 is ignored: reset is not re-pulsed and the byte stream is unchanged.
- R9: One cycle after the sixth byte's `spi_cs_n` rise, `busy` falls and `ready` rises. `ready` stays 1 until the next accepted start, and `busy` and `ready` are never both 1.
- R10: `spi_sclk` is 0 whenever `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a power-up sequence |
| cfg_bias | input | 3 | Bias level merged into the bias command |
| cfg_tc | input | 2 | Temperature coefficient merged into its command |
| cfg_vop | input | 7 | Operating voltage merged into its command |
| cfg_inv | input | 1 | 1 selects inverted display |
| lcd_rst_n | output | 1 | Active-low panel reset |
| lcd_dc | output | 1 | Data/command select, 0 for command bytes |
| spi_cs_n | output | 1 | Active-low chip select, framed per byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, most significant bit first |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Sequence finished, panel configured |

## Verification
The reset line falls and busy rises in the cycle after the start is sampled. The reset stays low for RST_US*CLK_HZ/1e6+1 cycles, and the first chip-select fall arrives settle+2 cycles after the release. Ready rises one cycle after the last chip-select rise. The bench samples every output on the falling clock edge, so registered changes from the preceding rising edge are always visible. Bytes are rebuilt from `spi_mosi` at each observed `spi_sclk` rise and compared against the expected stream once ready is seen. Pulse widths, settle time and serial phase lengths are measured as minimum bounds rather than exact counts.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_CMDS = 6;
    localparam int IDX_W    = 3;

    localparam logic [7:0] OP_FSET     = 8'h20;
    localparam logic [7:0] OP_EXT_BIT  = 8'h01;
    localparam logic [7:0] OP_BIAS     = 8'h10;
    localparam logic [7:0] OP_TEMPCO   = 8'h04;
    localparam logic [7:0] OP_VOLT     = 8'h80;
    localparam logic [7:0] OP_DISPMODE = 8'h0C;

    typedef struct packed {
        logic [2:0] bias;
        logic [1:0] tc;
        logic [6:0] vop;
        logic       inv;
    } lcd_cfg_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RST,
        SQ_SETTLE,
        SQ_SEND,
        SQ_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LOW,
        TX_HIGH,
        TX_TAIL
    } tx_state_t;

    function automatic int div_ceil(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic [7:0] cmd_byte(input logic [IDX_W-1:0] idx,
                                            input lcd_cfg_t cfg);
        logic [7:0] b;
        case (idx)
            3'd0:    b = OP_FSET | OP_EXT_BIT;
            3'd1:    b = OP_BIAS | {5'd0, cfg.bias};
            3'd2:    b = OP_TEMPCO | {6'd0, cfg.tc};
            3'd3:    b = OP_VOLT | {1'b0, cfg.vop};
            3'd4:    b = OP_FSET;
            default: b = OP_DISPMODE | {7'd0, cfg.inv};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            run  <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                cnt <= load_val;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= W'(1)) begin
                    fire <= 1'b1;
                    run  <= 1'b0;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lcd_spi_byte_tx.sv
module lcd_spi_byte_tx
    import lcd_seq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       tx_dc,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc,
    output logic       done
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

    tx_state_t     st;
    logic [DIV_W-1:0] div;
    logic [2:0]    bit_n;
    logic [7:0]    sh;
    logic          div_end;

    assign div_end = (div == DIV_LAST);
    assign mosi    = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            div   <= '0;
            bit_n <= '0;
            sh    <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            dc    <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (go) begin
                        sh    <= tx_byte;
                        dc    <= tx_dc;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b0;
                        div   <= '0;
                        bit_n <= '0;
                        st    <= TX_LOW;
                    end
                end
                TX_LOW: begin
                    if (div_end) begin
                        div  <= '0;
                        sclk <= 1'b1;
                        st   <= TX_HIGH;
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                TX_HIGH: begin
                    if (div_end) begin
                        div  <= '0;
                        sclk <= 1'b0;
                        if (bit_n == 3'd7) begin
                            st <= TX_TAIL;
                        end else begin
                            bit_n <= bit_n + 3'd1;
                            sh    <= {sh[6:0], 1'b0};
                            st    <= TX_LOW;
                        end
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                default: begin
                    if (div_end) begin
                        div  <= '0;
                        cs_n <= 1'b1;
                        done <= 1'b1;
                        st   <= TX_IDLE;
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lcd_cmd_sel.sv
module lcd_cmd_sel
    import lcd_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  lcd_cfg_t         cfg,
    output logic [7:0]       cmd
);
    always_comb cmd = cmd_byte(idx, cfg);
endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SPI_HZ    = 4_000_000,
    parameter int RST_US    = 20,
    parameter int SETTLE_US = 120_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] cfg_bias,
    input  logic [1:0] cfg_tc,
    input  logic [6:0] cfg_vop,
    input  logic       cfg_inv,
    output logic       lcd_rst_n,
    output logic       lcd_dc,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       busy,
    output logic       ready
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int RST_CYC    = CYC_PER_US * RST_US;
    localparam int SET_CYC    = CYC_PER_US * SETTLE_US;
    localparam int HALF_RAW   = div_ceil(CLK_HZ, 2 * SPI_HZ);
    localparam int HALF_DIV   = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int MAX_CYC    = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam int TMR_W      = $clog2(MAX_CYC + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CMDS - 1);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    lcd_cfg_t         cfg_q;
    lcd_cfg_t         cfg_in;
    logic             rst_n_q;
    logic             busy_q;
    logic             ready_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_fire;
    logic             tx_go;
    logic             tx_done;
    logic [7:0]       cur_cmd;

    always_comb begin
        cfg_in.bias = cfg_bias;
        cfg_in.tc   = cfg_tc;
        cfg_in.vop  = cfg_vop;
        cfg_in.inv  = cfg_inv;
    end

    always_comb begin
        tmr_load = ((state == SQ_IDLE) && start) || ((state == SQ_RST) && tmr_fire);
        tmr_val  = (state == SQ_IDLE) ? TMR_W'(RST_CYC) : TMR_W'(SET_CYC);
        tx_go    = (state == SQ_SEND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            cfg_q   <= '0;
            rst_n_q <= 1'b1;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        rst_n_q <= 1'b0;
                        busy_q  <= 1'b1;
                        ready_q <= 1'b0;
                        state   <= SQ_RST;
                    end
                end
                SQ_RST: begin
                    if (tmr_fire) begin
                        rst_n_q <= 1'b1;
                        state   <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (tmr_fire) begin
                        idx   <= '0;
                        state <= SQ_SEND;
                    end
                end
                SQ_SEND: state <= SQ_WAIT;
                default: begin
                    if (tx_done) begin
                        if (idx == LAST_IDX) begin
                            busy_q  <= 1'b0;
                            ready_q <= 1'b1;
                            state   <= SQ_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= SQ_SEND;
                        end
                    end
                end
            endcase
        end
    end

    lcd_delay_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .fire     (tmr_fire)
    );

    lcd_cmd_sel u_cmd (
        .idx (idx),
        .cfg (cfg_q),
        .cmd (cur_cmd)
    );

    lcd_spi_byte_tx #(.HALF(HALF_DIV)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .go      (tx_go),
        .tx_byte (cur_cmd),
        .tx_dc   (1'b0),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .dc      (lcd_dc),
        .done    (tx_done)
    );

    assign lcd_rst_n = rst_n_q;
    assign busy      = busy_q;
    assign ready     = ready_q;
endmodule

// File: rtl/lcd_pwrup_seq_chk.sv
module lcd_pwrup_seq_chk #(
    parameter int RST_CYC  = 20,
    parameter int SET_CYC  = 100,
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic lcd_rst_n,
    input logic lcd_dc,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic busy,
    input logic ready
);
    int unsigned low_cnt;
    int unsigned since_rel;
    int unsigned ph_cnt;
    logic        sclk_d;
    logic        cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= 0;
            since_rel <= 0;
            ph_cnt    <= 0;
            sclk_d    <= 1'b0;
            cs_d      <= 1'b1;
        end else begin
            sclk_d <= spi_sclk;
            cs_d   <= spi_cs_n;
            if (!lcd_rst_n) low_cnt <= low_cnt + 1;
            else            low_cnt <= 0;
            if (!lcd_rst_n)               since_rel <= 0;
            else if (since_rel < 32'hFFFF_FFF0) since_rel <= since_rel + 1;
            if ((spi_sclk != sclk_d) || (spi_cs_n != cs_d)) ph_cnt <= 1;
            else if (ph_cnt < 32'hFFFF_FFF0)                ph_cnt <= ph_cnt + 1;
        end
    end

    AST_START_PULLS_RESET: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!lcd_rst_n && busy && !ready)); // R2

    AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (lcd_rst_n && !$past(lcd_rst_n)) |-> (low_cnt >= RST_CYC)); // R3

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && cs_d) |-> (since_rel >= SET_CYC)); // R3

    AST_CMD_DC_LOW: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !lcd_dc); // R5

    AST_DC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && !cs_d) |-> $stable(lcd_dc)); // R5

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && sclk_d) |-> $stable(spi_mosi)); // R6

    AST_SCLK_PHASE: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk != sclk_d) |-> (ph_cnt >= HALF_DIV)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && busy && lcd_rst_n) |=> lcd_rst_n); // R8

    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R9

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R10
endmodule

bind lcd_pwrup_seq lcd_pwrup_seq_chk #(
    .RST_CYC  (RST_CYC),
    .SET_CYC  (SET_CYC),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lcd_rst_n (lcd_rst_n),
    .lcd_dc    (lcd_dc),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .busy      (busy),
    .ready     (ready)
);

// File: tb/lcd_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_pwrup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_CLK_HZ   = 10_000_000;
    localparam int P_SPI_HZ   = 2_500_000;
    localparam int P_RST_US   = 2;
    localparam int P_SET_US   = 10;
    localparam int EXP_RST    = (P_CLK_HZ / 1_000_000) * P_RST_US;
    localparam int EXP_SET    = (P_CLK_HZ / 1_000_000) * P_SET_US;
    localparam int EXP_HALF   = (P_CLK_HZ + 2 * P_SPI_HZ - 1) / (2 * P_SPI_HZ);
    localparam int WDOG_LIMIT = 150_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] cfg_bias = '0;
    logic [1:0] cfg_tc = '0;
    logic [6:0] cfg_vop = '0;
    logic cfg_inv = 1'b0;
    logic lcd_rst_n, lcd_dc, spi_cs_n, spi_sclk, spi_mosi, busy, ready;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pwrup_seq #(
        .CLK_HZ(P_CLK_HZ), .SPI_HZ(P_SPI_HZ),
        .RST_US(P_RST_US), .SETTLE_US(P_SET_US)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_bias(cfg_bias), .cfg_tc(cfg_tc), .cfg_vop(cfg_vop), .cfg_inv(cfg_inv),
        .lcd_rst_n(lcd_rst_n), .lcd_dc(lcd_dc), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .busy(busy), .ready(ready)
    );

    // Monitor state, written only by the monitor process
    logic       mon_clr = 1'b0;
    logic [7:0] cap [0:15];
    int   ncap, bitcnt, dc_bad, bits_bad, rst_falls, rst_low_len, low_run;
    int   since_rel, first_gap, gap_seen, min_phase, ph_run, idle_sclk;
    logic [7:0] shreg;
    logic prev_cs, prev_sclk, prev_rstn;

    always @(negedge clk) begin
        if (rst || mon_clr) begin
            ncap = 0; bitcnt = 0; dc_bad = 0; bits_bad = 0; rst_falls = 0;
            rst_low_len = 0; low_run = 0; since_rel = 0; first_gap = 0;
            gap_seen = 0; min_phase = 1000; ph_run = 0; idle_sclk = 0;
            shreg = 8'h00;
            prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_rstn = lcd_rst_n;
        end else begin
            if (prev_rstn && !lcd_rst_n) rst_falls++;
            if (!lcd_rst_n) begin low_run++; since_rel = 0; end
            else begin
                if (!prev_rstn) rst_low_len = low_run;
                low_run = 0;
                since_rel++;
            end
            if (spi_cs_n && spi_sclk) idle_sclk++;
            if (prev_cs && !spi_cs_n) begin
                bitcnt = 0;
                if (!gap_seen) begin first_gap = since_rel; gap_seen = 1; end
            end
            if ((spi_sclk != prev_sclk) || (spi_cs_n != prev_cs)) begin
                if (spi_sclk != prev_sclk && ph_run < min_phase) min_phase = ph_run;
                ph_run = 1;
            end else ph_run++;
            if (!spi_cs_n && lcd_dc) dc_bad++;
            if (!spi_cs_n && !prev_sclk && spi_sclk) begin
                shreg = {shreg[6:0], spi_mosi};
                bitcnt++;
            end
            if (!prev_cs && spi_cs_n) begin
                if (bitcnt != 8) bits_bad++;
                if (ncap < 16) cap[ncap] = shreg;
                ncap++;
            end
            prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_rstn = lcd_rst_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input int i, input logic [2:0] b,
                                           input logic [1:0] t, input logic [6:0] v,
                                           input logic inv);
        case (i)
            0: return 8'h21;
            1: return 8'h10 + {5'd0, b};
            2: return 8'h04 + {6'd0, t};
            3: return 8'h80 + {1'b0, v};
            4: return 8'h20;
            default: return inv ? 8'h0D : 8'h0C;
        endcase
    endfunction

    task automatic run_seq(input logic [2:0] b, input logic [1:0] t,
                           input logic [6:0] v, input logic inv, input bit disturb);
        int waited;
        @(negedge clk);
        mon_clr = 1'b1;
        cfg_bias = b; cfg_tc = t; cfg_vop = v; cfg_inv = inv;
        @(negedge clk);
        mon_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!lcd_rst_n && busy && !ready, "R2 start accepted", {lcd_rst_n, busy, ready}, 3'b010);
        if (disturb) begin
            repeat (EXP_RST + 20) @(negedge clk);
            cfg_bias = ~b; cfg_tc = ~t; cfg_vop = ~v; cfg_inv = ~inv;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            check(lcd_rst_n && busy, "R8 start while busy ignored", {lcd_rst_n, busy}, 2'b11);
        end
        waited = 0;
        while (!ready && waited < 5000) begin @(negedge clk); waited++; end
        check(ready && !busy, "R9 ready after sequence", {ready, busy}, 2'b10);
        check(spi_cs_n, "R9 chip select idle at end", spi_cs_n, 1);
        check(ncap == 6, "R4 byte count", ncap, 6);
        for (int i = 0; i < 6 && i < ncap; i++)
            check(cap[i] == exp_cmd(i, b, t, v, inv),
                  disturb ? "R7 captured config byte" : "R4 command byte",
                  cap[i], exp_cmd(i, b, t, v, inv));
        check(dc_bad == 0, "R5 dc low during bytes", dc_bad, 0);
        check(bits_bad == 0, "R6 eight clocks per byte", bits_bad, 0);
        check(min_phase >= EXP_HALF, "R6 sclk phase width", min_phase, EXP_HALF);
        check(idle_sclk == 0, "R10 sclk idle low", idle_sclk, 0);
        check(rst_falls == 1, "R8 single reset pulse", rst_falls, 1);
        check(rst_low_len >= EXP_RST, "R3 reset width", rst_low_len, EXP_RST);
        check(first_gap >= EXP_SET, "R3 settle gap", first_gap, EXP_SET);
    endtask

    initial begin : wdog
        int cyc = 0;
        while (cyc < WDOG_LIMIT) begin @(posedge clk); cyc++; end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG_LIMIT);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_1CD0));
        repeat (4) @(negedge clk);
        check(lcd_rst_n && spi_cs_n && !spi_sclk && !busy && !ready, "R1 state in reset",
              {lcd_rst_n, spi_cs_n, spi_sclk, busy, ready}, 5'b11000);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(lcd_rst_n && spi_cs_n && !spi_sclk && !busy && !ready, "R1 idle after reset",
              {lcd_rst_n, spi_cs_n, spi_sclk, busy, ready}, 5'b11000);
        run_seq(3'd4, 2'd0, 7'd0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(ready && !busy, "R9 ready holds", {ready, busy}, 2'b10);
        run_seq(3'd7, 2'd3, 7'h7F, 1'b1, 1'b0);
        run_seq(3'd0, 2'd0, 7'd0, 1'b0, 1'b0);
        run_seq(3'd2, 2'd1, 7'h55, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++)
            run_seq(3'($urandom), 2'($urandom), 7'($urandom), 1'($urandom), k[0]);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule